// File: doc/BRIEF.md
# Video Wall Tile Coordinate Mapper

This block sits in the display path of a video wall framestore. For every pixel of a 640x480 output raster it turns the current raster position into a read address into a half-resolution (320x240) framestore. The effect currently active on the monitor being drawn selects a magnification factor (1, 2, 3, 4 or 8) and a tile position. Together these pick which part of the magnified picture appears on this monitor. The mapping is computed with arithmetic rather than stored per-effect tables. The x3 case uses a small divide-by-three lookup, and the power-of-two cases use shifts.

The effect also says whether the monitor is frozen and whether it shows a flat colour wash. A frozen monitor reads from the frozen copy of the picture rather than the live buffer. A colour wash skips the mapping and presents a constant pixel value instead. All outputs are registered, one clock after the inputs.

Top module: `wall_coord_mapper`

## Requirements
- R1: While `rst_n` is low, and at the first clock edge after it, all outputs (`fs_x`, `fs_y`, `from_frozen`, `wash_out`, `wash_pix`) are zero.
- R2: Scale code 0 (x1), and the unused codes 5, 6 and 7, give `fs_x = vga_x/2` and `fs_y = vga_y/2` with integer division; the tile inputs are taken as zero-based offsets in units of one screen.
- R3: Scale codes 1 (x2), 3 (x4) and 4 (x8) give `fs_x = (tile_x*640 + vga_x) / (2*S)` and `fs_y = (tile_y*480 + vga_y) / (2*S)` with floor division, for tile positions below S.
- R4: Scale code 2 (x3) gives the same formula with S = 3, exact (floor) for every raster position and tile position 0..2.
- R5: With scale code 4 and tile positions 0..7 (the whole-wall view), the eight tiles split the framestore evenly: tile (0,0) at raster (0,0) reads (0,0), and tile (7,7) at raster (639,479) reads (319,239).
- R6: For a legal effect (tile position below S, raster inside 640x480), `fs_x` never exceeds 319 and `fs_y` never exceeds 239.
- R7: `from_frozen` follows `frozen_in` one clock later whenever `wash_in` is low.
- R8: When `wash_in` is high, the next clock gives `wash_out = 1`, `wash_pix = wash_rgb`, `fs_x = fs_y = 0` and `from_frozen = 0`, whatever `frozen_in` is; when `wash_in` is low, `wash_out = 0` and `wash_pix = 0`.
- R9: Latency is exactly one clock: outputs after an edge depend only on the inputs present at that edge, even when the inputs change every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vga_x | input | 10 | Raster column, 0..639 |
| vga_y | input | 9 | Raster row, 0..479 |
| scale_sel | input | 3 | Magnification: 0=x1, 1=x2, 2=x3, 3=x4, 4=x8, 5..7=x1 |
| tile_x | input | 3 | Horizontal tile position within the magnified picture |
| tile_y | input | 3 | Vertical tile position within the magnified picture |
| frozen_in | input | 1 | Effect is frozen |
| wash_in | input | 1 | Effect is a constant colour wash |
| wash_rgb | input | 9 | Colour value for the wash |
| fs_x | output | 9 | Framestore column, 0..319 |
| fs_y | output | 8 | Framestore row, 0..239 |
| from_frozen | output | 1 | Read from the frozen copy instead of the live buffer |
| wash_out | output | 1 | Pixel is the constant wash value |
| wash_pix | output | 9 | Wash value, zero when no wash |

## Verification
A wrong entry in the divide-by-three table appears only under scale code 2. It shows as a column or row that repeats or skips in `fs_x`/`fs_y` one clock after the raster reaches that value. For that reason the x3 case is swept over every column and row for all three tile positions. A wrong shift or offset product shows at once as a jump at tile boundaries, so each scale is checked at the first and last raster position of several tiles. Errors in the flag registers show as `from_frozen` or `wash_out` lagging or leading the inputs by a cycle, which the back-to-back stimulus exposes.

// File: rtl/cmap_pkg.sv
package cmap_pkg;

   typedef enum logic [2:0] {
      SC_X1 = 3'd0,
      SC_X2 = 3'd1,
      SC_X3 = 3'd2,
      SC_X4 = 3'd3,
      SC_X8 = 3'd4
   } scale_e;

   // Magnification factor for a scale code; unused codes act as x1.
   function automatic int unsigned scale_factor(input logic [2:0] code);
      case (code)
         3'd1:    return 2;
         3'd2:    return 3;
         3'd3:    return 4;
         3'd4:    return 8;
         default: return 1;
      endcase
   endfunction

endpackage

// File: rtl/cmap_div3.sv
// Floor division by three. The input is split as n = 64*a + b, which gives
// n/3 = 21*a + (a+b)/3, so only a short table over a+b is needed.
module cmap_div3 #(
   parameter int IN_W = 13
) (
   input  logic [IN_W-1:0] num_in,
   output logic [IN_W-1:0] quo_out
);
   localparam int HI_W  = IN_W - 6;
   localparam int DEPTH = (((1 << IN_W) - 1) >> 6) + 64;
   localparam int IDX_W = $clog2(DEPTH);
   localparam int LUT_W = $clog2(DEPTH / 3 + 1);

   if (IN_W <= 6) begin : g_bad_width
      $error("cmap_div3: IN_W must exceed 6");
   end

   logic [LUT_W-1:0] third_lut [DEPTH];
   logic [HI_W-1:0]  hi_part;
   logic [5:0]       lo_part;
   logic [IDX_W-1:0] lut_idx;

   for (genvar i = 0; i < DEPTH; i++) begin : g_lut
      assign third_lut[i] = LUT_W'(i / 3);
   end

   assign hi_part = num_in[IN_W-1:6];
   assign lo_part = num_in[5:0];
   assign lut_idx = IDX_W'(hi_part) + IDX_W'(lo_part);
   assign quo_out = IN_W'(hi_part) * IN_W'(21) + IN_W'(third_lut[lut_idx]);

endmodule

// File: rtl/cmap_axis.sv
// One axis of the mapper: offset the raster coordinate by whole screens,
// divide by twice the magnification and register the result.
module cmap_axis
   import cmap_pkg::*;
#(
   parameter int ACTIVE = 640,
   parameter int OFF_W  = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [$clog2(ACTIVE)-1:0]   v_in,
   input  logic [OFF_W-1:0]            off_in,
   input  logic [2:0]                  scale_in,
   input  logic                        zero_in,
   output logic [$clog2(ACTIVE/2)-1:0] f_out
);
   localparam int V_W   = $clog2(ACTIVE);
   localparam int F_W   = $clog2(ACTIVE / 2);
   localparam int NUM_W = $clog2((1 << OFF_W) * ACTIVE);
   localparam int F_MAX = ACTIVE / 2 - 1;

   if (ACTIVE % 2 != 0) begin : g_bad_active
      $error("cmap_axis: ACTIVE must be even");
   end
   if (OFF_W < 3) begin : g_bad_off
      $error("cmap_axis: OFF_W must cover tile positions up to 7");
   end

   logic [NUM_W-1:0] num;
   logic [NUM_W-1:0] q3;
   logic [NUM_W-1:0] quo;
   scale_e           sc;

   assign num = NUM_W'(off_in) * NUM_W'(ACTIVE) + NUM_W'(v_in);
   assign sc  = scale_e'(scale_in);

   cmap_div3 #(.IN_W(NUM_W)) u_div3 (
      .num_in  (num),
      .quo_out (q3)
   );

   always_comb begin
      case (sc)
         SC_X2:   quo = num >> 2;
         SC_X3:   quo = q3 >> 1;
         SC_X4:   quo = num >> 3;
         SC_X8:   quo = num >> 4;
         default: quo = num >> 1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       f_out <= '0;
      else if (zero_in) f_out <= '0;
      else              f_out <= F_W'(quo);
   end

   // Legal-input tracker for the range check.
   logic legal_q;
   always_ff @(posedge clk) begin
      if (!rst_n) legal_q <= 1'b0;
      else        legal_q <= (int'(v_in) < ACTIVE) &&
                             (int'(off_in) < int'(scale_factor(scale_in)));
   end

   // R6: output stays inside the framestore for legal effects
   p_fs_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      legal_q |-> (int'(f_out) <= F_MAX));

   // R4: divide-by-three lookup is an exact floor
   p_div3_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(q3) * 3 <= int'(num)) && (int'(num) < int'(q3) * 3 + 3));

   // R2: x1 with no offset halves the raster coordinate
   p_x1_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (scale_in == 3'd0 && off_in == '0 && !zero_in)
         |=> (int'(f_out) == int'($past(v_in)) / 2));

endmodule

// File: rtl/wall_coord_mapper.sv
module wall_coord_mapper #(
   parameter int H_ACTIVE = 640,
   parameter int V_ACTIVE = 480,
   parameter int OFF_W    = 3,
   parameter int COLOR_W  = 9
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [$clog2(H_ACTIVE)-1:0]   vga_x,
   input  logic [$clog2(V_ACTIVE)-1:0]   vga_y,
   input  logic [2:0]                    scale_sel,
   input  logic [OFF_W-1:0]              tile_x,
   input  logic [OFF_W-1:0]              tile_y,
   input  logic                          frozen_in,
   input  logic                          wash_in,
   input  logic [COLOR_W-1:0]            wash_rgb,
   output logic [$clog2(H_ACTIVE/2)-1:0] fs_x,
   output logic [$clog2(V_ACTIVE/2)-1:0] fs_y,
   output logic                          from_frozen,
   output logic                          wash_out,
   output logic [COLOR_W-1:0]            wash_pix
);

   if (COLOR_W < 1) begin : g_bad_color
      $error("wall_coord_mapper: COLOR_W must be positive");
   end
   if (H_ACTIVE < 64 || V_ACTIVE < 64) begin : g_bad_raster
      $error("wall_coord_mapper: raster too small");
   end

   cmap_axis #(.ACTIVE(H_ACTIVE), .OFF_W(OFF_W)) u_axis_x (
      .clk      (clk),
      .rst_n    (rst_n),
      .v_in     (vga_x),
      .off_in   (tile_x),
      .scale_in (scale_sel),
      .zero_in  (wash_in),
      .f_out    (fs_x)
   );

   cmap_axis #(.ACTIVE(V_ACTIVE), .OFF_W(OFF_W)) u_axis_y (
      .clk      (clk),
      .rst_n    (rst_n),
      .v_in     (vga_y),
      .off_in   (tile_y),
      .scale_in (scale_sel),
      .zero_in  (wash_in),
      .f_out    (fs_y)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         from_frozen <= 1'b0;
         wash_out    <= 1'b0;
         wash_pix    <= '0;
      end else begin
         from_frozen <= frozen_in & ~wash_in;
         wash_out    <= wash_in;
         wash_pix    <= wash_in ? wash_rgb : '0;
      end
   end

   // R8: a wash clears the read address and the frozen select
   p_wash_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wash_in |=> (wash_out && fs_x == '0 && fs_y == '0 && !from_frozen));

   // R8: no wash value leaks out when the wash is off
   p_wash_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wash_in |=> (!wash_out && wash_pix == '0));

   // R7: frozen effects select the frozen copy on the next cycle
   p_frozen_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen_in && !wash_in) |=> from_frozen);

endmodule

// File: tb/wall_coord_mapper_bench.sv
module wall_coord_mapper_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] vga_x = '0;
   logic [8:0] vga_y = '0;
   logic [2:0] scale_sel = '0;
   logic [2:0] tile_x = '0;
   logic [2:0] tile_y = '0;
   logic       frozen_in = 1'b0;
   logic       wash_in = 1'b0;
   logic [8:0] wash_rgb = '0;
   logic [8:0] fs_x;
   logic [7:0] fs_y;
   logic       from_frozen;
   logic       wash_out;
   logic [8:0] wash_pix;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   wall_coord_mapper u_wall_coord_mapper (
      .clk, .rst_n, .vga_x, .vga_y, .scale_sel, .tile_x, .tile_y,
      .frozen_in, .wash_in, .wash_rgb, .fs_x, .fs_y, .from_frozen,
      .wash_out, .wash_pix
   );

   function automatic int fac(input int code);
      case (code)
         1: return 2;
         2: return 3;
         3: return 4;
         4: return 8;
         default: return 1;
      endcase
   endfunction

   function automatic int exp_fx(input int code, input int ox, input int vx);
      return (ox * 640 + vx) / (2 * fac(code));
   endfunction

   function automatic int exp_fy(input int code, input int oy, input int vy);
      return (oy * 480 + vy) / (2 * fac(code));
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic drive(input int code, input int ox, input int oy, input int vx,
                        input int vy, input bit frz, input bit wsh, input int rgb);
      scale_sel = 3'(code); tile_x = 3'(ox); tile_y = 3'(oy);
      vga_x = 10'(vx); vga_y = 9'(vy);
      frozen_in = frz; wash_in = wsh; wash_rgb = 9'(rgb);
   endtask

   // Apply one pixel and check the coordinates one clock later.
   task automatic map_one(input string req, input int code, input int ox, input int oy,
                          input int vx, input int vy);
      @(negedge clk);
      drive(code, ox, oy, vx, vy, 1'b0, 1'b0, 0);
      @(negedge clk);
      chk(req, "fs_x", int'(fs_x), exp_fx(code, ox, vx));
      chk(req, "fs_y", int'(fs_y), exp_fy(code, oy, vy));
   endtask

   task automatic t_reset();
      @(negedge clk);
      drive(4, 7, 7, 639, 479, 1'b1, 1'b1, 9'h1ff);
      @(negedge clk);
      chk("R1", "fs_x in reset", int'(fs_x), 0);
      chk("R1", "fs_y in reset", int'(fs_y), 0);
      chk("R1", "from_frozen in reset", int'(from_frozen), 0);
      chk("R1", "wash_out in reset", int'(wash_out), 0);
      chk("R1", "wash_pix in reset", int'(wash_pix), 0);
      drive(0, 0, 0, 0, 0, 1'b0, 1'b0, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "fs_x after reset", int'(fs_x), 0);
      chk("R1", "wash_pix after reset", int'(wash_pix), 0);
   endtask

   task automatic t_direct();
      map_one("R2", 0, 0, 0, 0, 0);
      map_one("R2", 0, 0, 0, 639, 479);
      map_one("R2", 0, 0, 0, 321, 177);
      map_one("R2", 5, 0, 0, 455, 301);
      map_one("R2", 6, 0, 0, 1, 3);
      map_one("R2", 7, 0, 0, 638, 478);
   endtask

   task automatic t_pow2();
      foreach (fac_list[k]) begin
         for (int t = 0; t < fac(fac_list[k]); t++) begin
            map_one("R3", fac_list[k], t, t, 0, 0);
            map_one("R3", fac_list[k], t, fac(fac_list[k]) - 1 - t, 639, 479);
            map_one("R3", fac_list[k], t, 0, 317, 241);
         end
      end
   endtask
   int fac_list [3] = '{1, 3, 4};

   task automatic t_three();
      for (int t = 0; t < 3; t++) begin
         for (int v = 0; v < 640; v++) begin
            map_one("R4", 2, t, t, v, v % 480);
         end
      end
   endtask

   task automatic t_whole();
      map_one("R5", 4, 0, 0, 0, 0);
      map_one("R5", 4, 7, 7, 639, 479);
      @(negedge clk);
      drive(4, 7, 7, 639, 479, 1'b0, 1'b0, 0);
      @(negedge clk);
      chk("R5", "whole far corner fs_x", int'(fs_x), 319);
      chk("R5", "whole far corner fs_y", int'(fs_y), 239);
      chk("R6", "fs_x bound", int'(fs_x <= 9'd319), 1);
      for (int t = 0; t < 8; t++) begin
         map_one("R5", 4, t, 7 - t, 320, 240);
      end
   endtask

   task automatic t_freeze();
      @(negedge clk);
      drive(1, 1, 0, 100, 50, 1'b1, 1'b0, 0);
      @(negedge clk);
      chk("R7", "from_frozen set", int'(from_frozen), 1);
      chk("R7", "frozen fs_x", int'(fs_x), exp_fx(1, 1, 100));
      drive(1, 1, 0, 100, 50, 1'b0, 1'b0, 0);
      @(negedge clk);
      chk("R7", "from_frozen cleared", int'(from_frozen), 0);
   endtask

   task automatic t_wash();
      @(negedge clk);
      drive(3, 2, 1, 500, 400, 1'b1, 1'b1, 9'h0a5);
      @(negedge clk);
      chk("R8", "wash_out", int'(wash_out), 1);
      chk("R8", "wash_pix", int'(wash_pix), 9'h0a5);
      chk("R8", "wash fs_x", int'(fs_x), 0);
      chk("R8", "wash fs_y", int'(fs_y), 0);
      chk("R8", "wash from_frozen", int'(from_frozen), 0);
      drive(3, 2, 1, 500, 400, 1'b1, 1'b0, 9'h0a5);
      @(negedge clk);
      chk("R8", "wash_out off", int'(wash_out), 0);
      chk("R8", "wash_pix off", int'(wash_pix), 0);
      chk("R8", "mapped after wash", int'(fs_x), exp_fx(3, 2, 500));
   endtask

   task automatic t_pipeline();
      @(negedge clk);
      drive(2, 1, 2, 10, 20, 1'b1, 1'b0, 0);
      @(negedge clk);
      drive(4, 5, 3, 600, 450, 1'b0, 1'b1, 9'h133);
      chk("R9", "cycle A fs_x", int'(fs_x), exp_fx(2, 1, 10));
      chk("R9", "cycle A fs_y", int'(fs_y), exp_fy(2, 2, 20));
      chk("R9", "cycle A frozen", int'(from_frozen), 1);
      @(negedge clk);
      drive(0, 0, 0, 77, 99, 1'b0, 1'b0, 0);
      chk("R9", "cycle B wash_pix", int'(wash_pix), 9'h133);
      chk("R9", "cycle B frozen", int'(from_frozen), 0);
      @(negedge clk);
      chk("R9", "cycle C fs_x", int'(fs_x), 38);
      chk("R9", "cycle C fs_y", int'(fs_y), 49);
      chk("R9", "cycle C wash_out", int'(wash_out), 0);
   endtask

   initial begin
      t_reset();
      t_direct();
      t_pow2();
      t_three();
      t_whole();
      t_freeze();
      t_wash();
      t_pipeline();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule